// File: doc/BRIEF.md
# Display Controller I2C Register Slave

This block is the serial front end of a small seven-segment display controller. It follows a standard two-wire bus as a 7-bit slave, oversampling SCL and SDA with the system clock. It finds START and STOP conditions, takes in the address byte and acknowledges only when the address matches its own. In a write transfer the first byte after the address loads a register pointer. Every later byte is stored at the pointer, and the pointer then moves on by one. In a read transfer the slave returns bytes from the pointer, moving on after each byte, until the master answers with a NACK. The slave then lets go of SDA so that the master can close with STOP.

The block holds the controller's settings: eight digit bytes, the decode enable mask, the scan limit, the shutdown/run control, the feature byte, the test byte, a global brightness and four brightness registers, one for each pair of digits. Two read-only key bytes come in on ports. At power-up every device has slave address 0. One broadcast write to the self-address register makes each device latch its two strap pins into the two low address bits, so up to four devices can share one bus. The pad is reduced to an `sda_oe_o` pull-down enable.

Top module: `seg_i2c_slave`

## Requirements
- R1: After reset, sda_oe_o is 0, the slave address is 7'h00, run_o is 0 (shutdown), and decode_o, scan_limit_o, feature_o and all pair intensities are 0.
- R2: The slave drives ACK (SDA low) in the ninth bit of an address byte only if bits 7:1 equal its address. Otherwise it NACKs and ignores every bit up to the next START, including a later byte that would match.
- R3: In a write transfer the first byte after the address sets the register pointer, every later byte is written at the pointer, and every byte is ACKed. Register 0x09 holds all 8 bits, and digits sit at 0x01 to 0x08.
- R4: The pointer increments by one after each data byte that is written and after each byte that is read. A read with no pointer byte starts where the last transfer left off.
- R5: Read bytes go out MSB first. The slave sends the next byte when the master ACKs. On a master NACK it stops driving, and sda_oe_o stays 0 through the STOP.
- R6: A write to 0x0A stores its low nibble, which reads back with bits 7:4 at 0, and copies that nibble into both nibbles of the pair registers 0x10 to 0x13. A write to one pair register changes only that byte of pair_int_o (pair k at bits 8k+7:8k).
- R7: Shutdown register 0x0C: bit 0 is run (1) or shutdown (0). A write with bit 7 = 0 whose bit 0 differs from the current mode clears the feature register. With bit 7 = 1, or with no change of mode, the feature register is kept.
- R8: Writing 0x0E with bit 1 set returns decode, global intensity, scan limit, shutdown, test and pair registers to their reset values. It keeps digit data. It stores the written byte with bit 1 cleared.
- R9: Scan limit 0x0B and test 0x0F keep only bits 2:0. 0x1C and 0x1D read key_a_i and key_b_i. Writes to them, to diagnostics 0x14 to 0x1B and to unmapped addresses are ignored, and those last two read 0x00.
- R10: Writing 0x2D with bit 0 = 1 sets the address to {5'b0, strap_a1_i, strap_a0_i}, and 0x2D then reads 0x01. Writing bit 0 = 0 returns the address to 7'h00.
- R11: A START (SDA falling while SCL high) restarts address reception from any state, including in the middle of a transfer. sda_oe_o changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (resolved level) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_a0_i | input | 1 | Address bit 0 strap (short 0, open 1) |
| strap_a1_i | input | 1 | Address bit 1 strap (short 0, open 1) |
| key_a_i | input | 8 | Key bank A state, read at 0x1C |
| key_b_i | input | 8 | Key bank B state, read at 0x1D |
| dev_addr_o | output | 7 | Current slave address |
| run_o | output | 1 | 1 normal operation, 0 shutdown |
| decode_o | output | 8 | Per-digit decode enable mask |
| scan_limit_o | output | 3 | Highest scanned digit index |
| feature_o | output | 8 | Feature register |
| pair_int_o | output | 32 | Four digit-pair intensity bytes |

## Verification
On every cycle the checker confirms four things. SDA drive changes only while SCL is low. Each stored data byte advances the pointer by exactly one. A global intensity write shows up in every pair byte. The reset and shutdown side effects on the feature and control outputs follow their triggering writes. Other behaviour appears only over a whole bus transaction, so the bench's scenarios must show it: address matching and ignoring foreign traffic, read bursts ended by a NACK, restart in mid-transfer, read-back of the key and unmapped addresses, and the strap-driven change of address.

// File: rtl/seg_i2c_pkg.sv
package seg_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } bus_st_e;

  localparam logic [7:0] ADR_DIGIT0 = 8'h01;
  localparam logic [7:0] ADR_DECODE = 8'h09;
  localparam logic [7:0] ADR_GINT   = 8'h0A;
  localparam logic [7:0] ADR_SCAN   = 8'h0B;
  localparam logic [7:0] ADR_SHUT   = 8'h0C;
  localparam logic [7:0] ADR_FEAT   = 8'h0E;
  localparam logic [7:0] ADR_TEST   = 8'h0F;
  localparam logic [7:0] ADR_PAIR0  = 8'h10;
  localparam logic [7:0] ADR_KEYA   = 8'h1C;
  localparam logic [7:0] ADR_KEYB   = 8'h1D;
  localparam logic [7:0] ADR_SELF   = 8'h2D;

  localparam int FEAT_RST_BIT = 1;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] scl_sh, sda_sh;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end
  end

  assign scl_o    = scl_sh[STAGES-1];
  assign sda_o    = sda_sh[STAGES-1];
  assign scl_prev = scl_sh[STAGES];
  assign sda_prev = sda_sh[STAGES];

  assign start_o = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_o  = scl_o & scl_prev & ~sda_prev & sda_o;
  assign rise_o  = scl_o & ~scl_prev;
  assign fall_o  = ~scl_o & scl_prev;
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import seg_i2c_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_s_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [AW-1:0] dev_addr_i,
  input  logic [DW-1:0] rdata_i,
  output logic          sda_oe_o,
  output logic [DW-1:0] ptr_o,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_data_o,
  output logic          busy_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] BYTE_DONE = CW'(DW);
  localparam logic [CW-1:0] LAST_BIT  = CW'(DW - 1);

  bus_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] rx_q, tx_q, ptr_q, wdat_q;
  logic          oe_q, rw_q, first_q, wen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      wdat_q  <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      wen_q   <= 1'b0;
    end else begin
      wen_q <= 1'b0;
      if (wen_q) ptr_q <= ptr_q + 1'b1;
      if (start_i) begin
        st_q  <= ST_ADDR;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else if (stop_i) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_WR: begin
            if (rise_i) begin
              rx_q  <= {rx_q[DW-2:0], sda_s_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (fall_i && cnt_q == BYTE_DONE) begin
              cnt_q <= '0;
              if (st_q == ST_ADDR) begin
                if (rx_q[DW-1:1] == dev_addr_i) begin
                  st_q    <= ST_ADDR_ACK;
                  oe_q    <= 1'b1;
                  rw_q    <= rx_q[0];
                  first_q <= 1'b1;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else begin
                st_q <= ST_WR_ACK;
                oe_q <= 1'b1;
                if (first_q) begin
                  ptr_q   <= rx_q;
                  first_q <= 1'b0;
                end else begin
                  wen_q  <= 1'b1;
                  wdat_q <= rx_q;
                end
              end
            end
          end
          ST_ADDR_ACK, ST_WR_ACK: begin
            if (fall_i) begin
              cnt_q <= '0;
              if (st_q == ST_ADDR_ACK && rw_q) begin
                st_q <= ST_RD;
                tx_q <= rdata_i;
                oe_q <= ~rdata_i[DW-1];
              end else begin
                st_q <= ST_WR;
                oe_q <= 1'b0;
              end
            end
          end
          ST_RD: begin
            if (fall_i) begin
              if (cnt_q == LAST_BIT) begin
                st_q  <= ST_RD_ACK;
                oe_q  <= 1'b0;
                ptr_q <= ptr_q + 1'b1;
              end else begin
                tx_q  <= {tx_q[DW-2:0], 1'b0};
                oe_q  <= ~tx_q[DW-2];
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (rise_i && sda_s_i) begin
              st_q <= ST_IDLE;
            end else if (fall_i) begin
              st_q  <= ST_RD;
              tx_q  <= rdata_i;
              oe_q  <= ~rdata_i[DW-1];
              cnt_q <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign ptr_o     = ptr_q;
  assign wr_en_o   = wen_q;
  assign wr_data_o = wdat_q;
  assign busy_o    = (st_q != ST_IDLE);
endmodule

// File: rtl/seg_ctrl_regs.sv
module seg_ctrl_regs
  import seg_i2c_pkg::*;
#(
  parameter int N_DIGITS = 8,
  localparam int N_PAIRS = N_DIGITS / 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [7:0]           addr_i,
  input  logic [7:0]           wdata_i,
  input  logic                 strap_a0_i,
  input  logic                 strap_a1_i,
  input  logic [7:0]           key_a_i,
  input  logic [7:0]           key_b_i,
  output logic [7:0]           rdata_o,
  output logic [6:0]           dev_addr_o,
  output logic                 run_o,
  output logic [7:0]           decode_o,
  output logic [2:0]           scan_limit_o,
  output logic [7:0]           feature_o,
  output logic [N_PAIRS*8-1:0] pair_int_o
);
  logic [N_DIGITS*8-1:0] digit_bus;
  logic [7:0] decode_q, shut_q, feat_q;
  logic [3:0] gint_q;
  logic [2:0] scan_q, test_q;
  logic [1:0] lsb_q;
  logic       user_q;

  logic gint_wr, feat_wr, ctl_rst, shut_wr, mode_flip;
  assign gint_wr   = we_i && addr_i == ADR_GINT;
  assign feat_wr   = we_i && addr_i == ADR_FEAT;
  assign ctl_rst   = feat_wr && wdata_i[FEAT_RST_BIT];
  assign shut_wr   = we_i && addr_i == ADR_SHUT;
  assign mode_flip = wdata_i[0] != shut_q[0];

  for (genvar g = 0; g < N_DIGITS; g++) begin : gen_digit
    localparam logic [7:0] MY_ADR = 8'(ADR_DIGIT0 + g);
    logic [7:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       val_q <= '0;
      else if (we_i && addr_i == MY_ADR) val_q <= wdata_i;
    end
    assign digit_bus[g*8 +: 8] = val_q;
  end

  for (genvar g = 0; g < N_PAIRS; g++) begin : gen_pair
    localparam logic [7:0] MY_ADR = 8'(ADR_PAIR0 + g);
    logic [7:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       val_q <= '0;
      else if (ctl_rst)                  val_q <= '0;
      else if (gint_wr)                  val_q <= {wdata_i[3:0], wdata_i[3:0]};
      else if (we_i && addr_i == MY_ADR) val_q <= wdata_i;
    end
    assign pair_int_o[g*8 +: 8] = val_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      decode_q <= '0;
      gint_q   <= '0;
      scan_q   <= '0;
      shut_q   <= '0;
      test_q   <= '0;
      lsb_q    <= '0;
      user_q   <= 1'b0;
    end else if (ctl_rst) begin
      decode_q <= '0;
      gint_q   <= '0;
      scan_q   <= '0;
      shut_q   <= '0;
      test_q   <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADR_DECODE: decode_q <= wdata_i;
        ADR_GINT:   gint_q   <= wdata_i[3:0];
        ADR_SCAN:   scan_q   <= wdata_i[2:0];
        ADR_SHUT:   shut_q   <= wdata_i;
        ADR_TEST:   test_q   <= wdata_i[2:0];
        ADR_SELF: begin
          user_q <= wdata_i[0];
          lsb_q  <= wdata_i[0] ? {strap_a1_i, strap_a0_i} : 2'b00;
        end
        default: ;
      endcase
    end
  end

  // feature byte: own write wins, else cleared by a mode flip with d7 low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            feat_q <= '0;
    else if (feat_wr)                       feat_q <= wdata_i & ~(8'(1) << FEAT_RST_BIT);
    else if (shut_wr && !wdata_i[7] && mode_flip) feat_q <= '0;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_DECODE: rdata_o = decode_q;
      ADR_GINT:   rdata_o = {4'h0, gint_q};
      ADR_SCAN:   rdata_o = {5'h00, scan_q};
      ADR_SHUT:   rdata_o = shut_q;
      ADR_FEAT:   rdata_o = feat_q;
      ADR_TEST:   rdata_o = {5'h00, test_q};
      ADR_KEYA:   rdata_o = key_a_i;
      ADR_KEYB:   rdata_o = key_b_i;
      ADR_SELF:   rdata_o = {7'h00, user_q};
      default: ;
    endcase
    for (int i = 0; i < N_DIGITS; i++)
      if (addr_i == 8'(ADR_DIGIT0 + i)) rdata_o = digit_bus[i*8 +: 8];
    for (int i = 0; i < N_PAIRS; i++)
      if (addr_i == 8'(ADR_PAIR0 + i)) rdata_o = pair_int_o[i*8 +: 8];
  end

  assign dev_addr_o   = {5'b00000, lsb_q};
  assign run_o        = shut_q[0];
  assign decode_o     = decode_q;
  assign scan_limit_o = scan_q;
  assign feature_o    = feat_q;
endmodule

// File: rtl/seg_i2c_slave.sv
module seg_i2c_slave #(
  parameter int N_DIGITS    = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PAIR_W     = (N_DIGITS / 2) * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              strap_a0_i,
  input  logic              strap_a1_i,
  input  logic [7:0]        key_a_i,
  input  logic [7:0]        key_b_i,
  output logic [6:0]        dev_addr_o,
  output logic              run_o,
  output logic [7:0]        decode_o,
  output logic [2:0]        scan_limit_o,
  output logic [7:0]        feature_o,
  output logic [PAIR_W-1:0] pair_int_o
);
  logic scl_s, sda_s, start_p, stop_p, rise_p, fall_p;
  logic wr_en, busy;
  logic [7:0] ptr, wr_data, rdata;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .start_o(start_p), .stop_o(stop_p),
    .rise_o(rise_p), .fall_o(fall_p)
  );

  i2c_slave_fsm #(.AW(7), .DW(8)) u_fsm (
    .clk_i, .rst_ni, .sda_s_i(sda_s), .start_i(start_p), .stop_i(stop_p),
    .rise_i(rise_p), .fall_i(fall_p), .dev_addr_i(dev_addr_o), .rdata_i(rdata),
    .sda_oe_o, .ptr_o(ptr), .wr_en_o(wr_en), .wr_data_o(wr_data), .busy_o(busy)
  );

  seg_ctrl_regs #(.N_DIGITS(N_DIGITS)) u_regs (
    .clk_i, .rst_ni, .we_i(wr_en), .addr_i(ptr), .wdata_i(wr_data),
    .strap_a0_i, .strap_a1_i, .key_a_i, .key_b_i, .rdata_o(rdata),
    .dev_addr_o, .run_o, .decode_o, .scan_limit_o, .feature_o, .pair_int_o
  );
endmodule

// File: rtl/seg_i2c_slave_chk.sv
module seg_i2c_slave_chk
  import seg_i2c_pkg::*;
#(
  parameter int N_PAIRS = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               scl_s,
  input logic               sda_oe_o,
  input logic               wr_en,
  input logic [7:0]         wr_data,
  input logic [7:0]         ptr,
  input logic               run_o,
  input logic [7:0]         decode_o,
  input logic [2:0]         scan_limit_o,
  input logic [7:0]         feature_o,
  input logic [6:0]         dev_addr_o,
  input logic [N_PAIRS*8-1:0] pair_int_o
);
  logic [N_PAIRS*8-1:0] fan_exp;
  always_comb
    for (int i = 0; i < N_PAIRS; i++) fan_exp[i*8 +: 8] = {wr_data[3:0], wr_data[3:0]};

  assert_oe_scl_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_s));

  assert_ptr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en) |-> ptr == $past(ptr) + 8'd1);

  assert_gint_fanout_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en && ptr == ADR_GINT) |-> pair_int_o == $past(fan_exp));

  assert_ctl_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en && ptr == ADR_FEAT && wr_data[FEAT_RST_BIT])
      |-> (decode_o == 8'h00 && scan_limit_o == 3'd0 && !run_o && pair_int_o == '0));

  assert_feat_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en && ptr == ADR_SHUT && !wr_data[7] && (wr_data[0] != run_o))
      |-> feature_o == 8'h00);

  assert_addr_upper_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_addr_o[6:2] == 5'b00000);
endmodule

bind seg_i2c_slave seg_i2c_slave_chk #(.N_PAIRS(N_DIGITS / 2)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .sda_oe_o(sda_oe_o),
  .wr_en(wr_en), .wr_data(wr_data), .ptr(ptr), .run_o(run_o),
  .decode_o(decode_o), .scan_limit_o(scan_limit_o), .feature_o(feature_o),
  .dev_addr_o(dev_addr_o), .pair_int_o(pair_int_o)
);

// File: tb/seg_i2c_slave_bench.sv
module seg_i2c_slave_bench;
  localparam int HP = 10;
  localparam logic [7:0] KEY_A = 8'h96;
  localparam logic [7:0] KEY_B = 8'h3E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic a0 = 1'b0, a1 = 1'b1;
  logic sda_oe;
  logic [6:0] dev_addr;
  logic run;
  logic [7:0] decode, feature;
  logic [2:0] scan;
  logic [31:0] pairs;
  wire sda_line = sda_m & ~sda_oe;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  seg_i2c_slave u_seg_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_a0_i(a0), .strap_a1_i(a1),
    .key_a_i(KEY_A), .key_b_i(KEY_B), .dev_addr_o(dev_addr), .run_o(run),
    .decode_o(decode), .scan_limit_o(scan), .feature_o(feature), .pair_int_o(pairs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1'b1; wt(HP); scl_m = 1'b1; wt(HP); sda_m = 1'b0; wt(HP); scl_m = 1'b0; wt(2);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wt(HP); scl_m = 1'b1; wt(HP); sda_m = 1'b1; wt(HP);
  endtask

  task automatic bus_bit(input logic b, output logic r);
    sda_m = b; wt(HP); scl_m = 1'b1; wt(HP / 2); r = sda_line; wt(HP / 2); scl_m = 1'b0; wt(2);
  endtask

  task automatic byte_wr(input logic [7:0] d, output logic nack);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], r);
    bus_bit(1'b1, nack);
  endtask

  task automatic byte_rd(input logic last, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, r); d[i] = r; end
    bus_bit(last, r);
  endtask

  task automatic wr1(input logic [6:0] dev, input logic [7:0] p, input logic [7:0] d,
                     output logic nack_any);
    logic n0, n1, n2;
    bus_start; byte_wr({dev, 1'b0}, n0); byte_wr(p, n1); byte_wr(d, n2); bus_stop;
    nack_any = n0 | n1 | n2;
  endtask

  task automatic rd1(input logic [6:0] dev, input logic [7:0] p, output logic [7:0] d);
    logic n;
    bus_start; byte_wr({dev, 1'b0}, n); byte_wr(p, n);
    bus_start; byte_wr({dev, 1'b1}, n); byte_rd(1'b1, d); bus_stop;
  endtask

  // {r9 flag, pointer, write data, expected read}
  localparam logic [24:0] VEC [9] = '{
    {1'b0, 8'h03, 8'h5A, 8'h5A},
    {1'b0, 8'h08, 8'hC3, 8'hC3},
    {1'b0, 8'h09, 8'hA5, 8'hA5},
    {1'b1, 8'h0B, 8'hFF, 8'h07},
    {1'b1, 8'h0F, 8'hFF, 8'h07},
    {1'b1, 8'h1C, 8'h00, KEY_A},
    {1'b1, 8'h1D, 8'h11, KEY_B},
    {1'b1, 8'h20, 8'h55, 8'h00},
    {1'b1, 8'h15, 8'h77, 8'h00}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic n, n1, n2, n3;
    logic [7:0] d;
    wt(4);
    // R1 reset state
    chk("R1", {sda_oe, dev_addr, run, decode, scan, feature},
        {1'b0, 7'h00, 1'b0, 8'h00, 3'd0, 8'h00});
    chk("R1 pairs", pairs, 32'h0);
    rst_n = 1'b1;
    wt(4);

    // R3, R9 table of write/read-back vectors
    for (int i = 0; i < 9; i++) begin
      wr1(7'h00, VEC[i][23:16], VEC[i][15:8], n);
      rd1(7'h00, VEC[i][23:16], d);
      chk(VEC[i][24] ? "R9 readback" : "R3 readback", {n, d}, {1'b0, VEC[i][7:0]});
    end
    chk("R3 decode_o", decode, 8'hA5);

    // R2 foreign address: NACK, later matching byte ignored, no write
    bus_start; byte_wr({7'h05, 1'b0}, n1); byte_wr(8'h00, n2); byte_wr(8'h00, n3); bus_stop;
    chk("R2 nack", {n1, n2, n3}, 3'b111);
    chk("R2 no write", decode, 8'hA5);

    // R11 repeated START mid-write restarts addressing
    bus_start; byte_wr(8'h00, n); byte_wr(8'h09, n);
    bus_start; byte_wr(8'h00, n1); byte_wr(8'h0B, n2); byte_wr(8'h03, n3); bus_stop;
    chk("R11 restart", {n1, n2, n3, scan, decode}, {3'b000, 3'd3, 8'hA5});

    // R4, R5 burst write then burst read, then read with no pointer byte
    bus_start; byte_wr(8'h00, n); byte_wr(8'h04, n);
    byte_wr(8'h11, n1); byte_wr(8'h22, n2); byte_wr(8'h33, n3); byte_wr(8'h44, n); bus_stop;
    chk("R4 burst ack", {n1, n2, n3, n}, 4'b0000);
    bus_start; byte_wr(8'h00, n); byte_wr(8'h04, n);
    bus_start; byte_wr(8'h01, n);
    byte_rd(1'b0, d); chk("R5 byte0", d, 8'h11);
    byte_rd(1'b0, d); chk("R5 byte1", d, 8'h22);
    byte_rd(1'b1, d); chk("R5 byte2", d, 8'h33);
    chk("R5 released after nack", sda_oe, 1'b0);
    bus_stop;
    chk("R5 released after stop", sda_oe, 1'b0);
    bus_start; byte_wr(8'h01, n); byte_rd(1'b1, d); bus_stop;
    chk("R4 pointer carried", d, 8'h44);

    // R6 global intensity fan-out and single pair write
    wr1(7'h00, 8'h0A, 8'h27, n);
    chk("R6 fanout", pairs, 32'h7777_7777);
    rd1(7'h00, 8'h0A, d);
    chk("R6 gint readback", d, 8'h07);
    wr1(7'h00, 8'h11, 8'h3C, n);
    chk("R6 one pair", pairs, 32'h7777_3C77);
    rd1(7'h00, 8'h13, d);
    chk("R6 other pair", d, 8'h77);

    // R7 shutdown and feature interaction
    wr1(7'h00, 8'h0E, 8'h05, n);
    chk("R7 feature set", feature, 8'h05);
    wr1(7'h00, 8'h0C, 8'h81, n);
    chk("R7 run keep", {run, feature}, {1'b1, 8'h05});
    wr1(7'h00, 8'h0C, 8'h01, n);
    chk("R7 no flip keep", {run, feature}, {1'b1, 8'h05});
    wr1(7'h00, 8'h0C, 8'h00, n);
    chk("R7 flip clear", {run, feature}, {1'b0, 8'h00});

    // R8 control reset through feature bit 1
    wr1(7'h00, 8'h01, 8'h42, n);
    wr1(7'h00, 8'h09, 8'hFF, n);
    wr1(7'h00, 8'h0C, 8'h81, n);
    wr1(7'h00, 8'h0E, 8'h06, n);
    chk("R8 ctl reset", {decode, scan, run, feature}, {8'h00, 3'd0, 1'b0, 8'h04});
    chk("R8 pairs reset", pairs, 32'h0);
    rd1(7'h00, 8'h01, d);
    chk("R8 digit kept", d, 8'h42);

    // R10 self addressing from straps (a1=1, a0=0)
    wr1(7'h00, 8'h2D, 8'h01, n);
    chk("R10 new address", dev_addr, 7'h02);
    bus_start; byte_wr(8'h00, n1); bus_stop;
    bus_start; byte_wr(8'h04, n2); bus_stop;
    chk("R10 ack pattern", {n1, n2}, 2'b10);
    rd1(7'h02, 8'h2D, d);
    chk("R10 readback", d, 8'h01);
    wr1(7'h02, 8'h2D, 8'h00, n);
    chk("R10 back to zero", dev_addr, 7'h00);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule